// File: doc/BRIEF.md
# Sampled PI Controller with Direction-Aware Integrator Freeze

This block is a fixed-point proportional-integral controller for a single loop. On every one-cycle sample strobe it subtracts the measured process value from the setpoint. It adds the integral accumulator to the proportional product and scales the sum by a fixed binary point. The result is the raw request, and a copy of it limited to the actuator range `0 .. OUT_MAX` is the command. Both are registered and appear on the cycle after the strobe.

The integrator does not wind up. A small state machine records the region that the previous sample's command landed in. The three regions are `REG_LINEAR`, `REG_UPPER` (command at its full-scale limit) and `REG_LOWER` (command at zero). The integrator holds only when the recorded region is `REG_UPPER` and the error is positive, or the region is `REG_LOWER` and the error is negative. Every other strobe integrates. The next region is taken from the new request. `REG_UPPER` is entered when the request is at or above `OUT_MAX`. `REG_LOWER` is entered when the request is at or below zero. Otherwise the state is `REG_LINEAR`. Reset forces `REG_LINEAR`. The accumulator is several bits wider than the product terms and saturates at its own numeric bounds.

Top module: `pi_antiwindup_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `req_o` and `cmd_o` to 0, deasserts both saturation flags, empties the accumulator and returns the region state to `REG_LINEAR`.
- R2: On a strobe, err = setpoint − measured. The accumulator then becomes acc + ki·err, unless it is held. `req_o` becomes (kp·err + new acc) shifted right arithmetically by `FRAC` bits. All outputs update on the clock edge that samples the strobe.
- R3: `cmd_o` equals `OUT_MAX` when the request is at or above `OUT_MAX`, 0 when the request is at or below 0, and the request otherwise, so `cmd_o` never exceeds `OUT_MAX`.
- R4: `sat_hi_o` is 1 exactly when the latest request was at or above `OUT_MAX`. `sat_lo_o` is 1 exactly when it was at or below 0. The two flags are never both 1.
- R5: On a strobe with `sat_hi_o` = 1 and a positive error, the accumulator keeps its value.
- R6: On a strobe with `sat_lo_o` = 1 and a negative error, the accumulator keeps its value.
- R7: On a strobe where the command sits at a limit and the error points back toward the usable range, the accumulator still integrates.
- R8: The hold decision uses the region stored from the previous strobe. The strobe that first drives the request past a limit therefore still integrates.
- R9: When acc + ki·err leaves the signed range of the accumulator, the accumulator stops at the nearest bound and does not wrap.
- R10: Without a strobe, `req_o`, `cmd_o` and both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle sample strobe |
| setpoint_i | input | DW | Signed setpoint |
| measured_i | input | DW | Signed measured process value |
| kp_i | input | GW | Unsigned proportional gain, `FRAC` fraction bits |
| ki_i | input | GW | Unsigned per-sample integral gain, `FRAC` fraction bits |
| req_o | output | DW+GW+ACC_GUARD+3 | Signed unlimited output request |
| cmd_o | output | OW | Command limited to 0 .. OUT_MAX |
| sat_hi_o | output | 1 | Command at the upper limit |
| sat_lo_o | output | 1 | Command at the lower limit |

## Verification
The bound checker checks the following on every cycle: the command range, the exclusivity of the two flags, the agreement between each flag and its limit value, output stability between strobes, the clearing effect of reset, and the holding of the accumulator in both directional freeze cases. The bench scenarios cover the arithmetic values. These include the strobe that enters saturation while still integrating, integration resuming against the limit, requests landing exactly on 0 and on `OUT_MAX`, and accumulator saturation in a wide-range instance. Only a reference model of the update equations can judge those values.

// File: rtl/pi_aw_pkg.sv
package pi_aw_pkg;

    // Region of the most recent limited command
    typedef enum logic [1:0] {
        REG_LINEAR = 2'd0,
        REG_UPPER  = 2'd1,
        REG_LOWER  = 2'd2
    } region_e;

endpackage

// File: rtl/pi_error_unit.sv
module pi_error_unit #(
    parameter int DW = 16,
    parameter int GW = 12,
    localparam int EW = DW + 1,
    localparam int PW = DW + GW + 2
) (
    input  logic signed [DW-1:0] setpoint_i,
    input  logic signed [DW-1:0] measured_i,
    input  logic        [GW-1:0] kp_i,
    input  logic        [GW-1:0] ki_i,
    output logic signed [EW-1:0] err_o,
    output logic signed [PW-1:0] p_term_o,
    output logic signed [PW-1:0] i_term_o,
    output logic                 err_pos_o,
    output logic                 err_neg_o
);

    logic signed [GW:0] kp_s;
    logic signed [GW:0] ki_s;

    always_comb begin
        err_o     = {setpoint_i[DW-1], setpoint_i} - {measured_i[DW-1], measured_i};
        kp_s      = {1'b0, kp_i};
        ki_s      = {1'b0, ki_i};
        p_term_o  = err_o * kp_s;
        i_term_o  = err_o * ki_s;
        err_neg_o = err_o[EW-1];
        err_pos_o = !err_o[EW-1] && (err_o != '0);
    end

endmodule

// File: rtl/pi_integrator.sv
module pi_integrator #(
    parameter int PW = 30,
    parameter int AW = 36,
    localparam int EXT = AW + 1 - PW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 hold,
    input  logic signed [PW-1:0] inc,
    output logic signed [AW-1:0] acc_q,
    output logic signed [AW-1:0] acc_next
);

    localparam logic signed [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

    logic signed [AW:0]   sum_w;
    logic signed [AW-1:0] sat_w;

    always_comb begin
        sum_w = {acc_q[AW-1], acc_q} + {{EXT{inc[PW-1]}}, inc};
        if (sum_w[AW] != sum_w[AW-1]) begin
            sat_w = sum_w[AW] ? ACC_MIN : ACC_MAX;
        end else begin
            sat_w = sum_w[AW-1:0];
        end
        acc_next = hold ? acc_q : sat_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/pi_limiter.sv
module pi_limiter
    import pi_aw_pkg::*;
#(
    parameter int SW      = 37,
    parameter int OW      = 16,
    parameter int OUT_MAX = 1000,
    parameter int FRAC    = 8
) (
    input  logic signed [SW-1:0] sum_i,
    output logic signed [SW-1:0] req_o,
    output logic        [OW-1:0] cmd_o,
    output region_e              region_o
);

    localparam logic signed [SW-1:0] LIM_HI = SW'(OUT_MAX);

    always_comb begin
        req_o = sum_i >>> FRAC;
        if (req_o >= LIM_HI) begin
            region_o = REG_UPPER;
            cmd_o    = OW'(OUT_MAX);
        end else if (req_o <= 0) begin
            region_o = REG_LOWER;
            cmd_o    = '0;
        end else begin
            region_o = REG_LINEAR;
            cmd_o    = req_o[OW-1:0];
        end
    end

endmodule

// File: rtl/pi_antiwindup_ctrl.sv
module pi_antiwindup_ctrl
    import pi_aw_pkg::*;
#(
    parameter int DW        = 16,
    parameter int GW        = 12,
    parameter int ACC_GUARD = 6,
    parameter int FRAC      = 8,
    parameter int OW        = 16,
    parameter int OUT_MAX   = 1000
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 smp_stb,
    input  logic signed [DW-1:0]                 setpoint_i,
    input  logic signed [DW-1:0]                 measured_i,
    input  logic        [GW-1:0]                 kp_i,
    input  logic        [GW-1:0]                 ki_i,
    output logic signed [DW+GW+ACC_GUARD+2:0]    req_o,
    output logic        [OW-1:0]                 cmd_o,
    output logic                                 sat_hi_o,
    output logic                                 sat_lo_o
);

    localparam int EW = DW + 1;
    localparam int PW = DW + GW + 2;
    localparam int AW = PW + ACC_GUARD;
    localparam int SW = AW + 1;

    logic signed [EW-1:0] err_w;
    logic signed [PW-1:0] p_term_w;
    logic signed [PW-1:0] i_term_w;
    logic                 err_pos_w;
    logic                 err_neg_w;
    logic signed [AW-1:0] acc_q_w;
    logic signed [AW-1:0] acc_next_w;
    logic signed [SW-1:0] total_w;
    logic signed [SW-1:0] req_w;
    logic        [OW-1:0] cmd_w;
    logic                 hold_w;
    region_e              region_q;
    region_e              region_d;

    pi_error_unit #(.DW(DW), .GW(GW)) u_err (
        .setpoint_i (setpoint_i),
        .measured_i (measured_i),
        .kp_i       (kp_i),
        .ki_i       (ki_i),
        .err_o      (err_w),
        .p_term_o   (p_term_w),
        .i_term_o   (i_term_w),
        .err_pos_o  (err_pos_w),
        .err_neg_o  (err_neg_w)
    );

    // Direction-aware freeze, decided from the stored region
    always_comb begin
        unique case (region_q)
            REG_UPPER:  hold_w = err_pos_w;
            REG_LOWER:  hold_w = err_neg_w;
            REG_LINEAR: hold_w = 1'b0;
            default:    hold_w = 1'b0;
        endcase
    end

    pi_integrator #(.PW(PW), .AW(AW)) u_int (
        .clk      (clk),
        .rst      (rst),
        .en       (smp_stb),
        .hold     (hold_w),
        .inc      (i_term_w),
        .acc_q    (acc_q_w),
        .acc_next (acc_next_w)
    );

    assign total_w = {{(SW-PW){p_term_w[PW-1]}}, p_term_w} + {acc_next_w[AW-1], acc_next_w};

    pi_limiter #(.SW(SW), .OW(OW), .OUT_MAX(OUT_MAX), .FRAC(FRAC)) u_lim (
        .sum_i    (total_w),
        .req_o    (req_w),
        .cmd_o    (cmd_w),
        .region_o (region_d)
    );

    // State register: region of the latest command
    always_ff @(posedge clk) begin
        if (rst) begin
            region_q <= REG_LINEAR;
        end else if (smp_stb) begin
            region_q <= region_d;
        end
    end

    // Data output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            req_o <= '0;
            cmd_o <= '0;
        end else if (smp_stb) begin
            req_o <= req_w;
            cmd_o <= cmd_w;
        end
    end

    // Flag outputs decoded from the state
    always_comb begin
        unique case (region_q)
            REG_UPPER:  begin sat_hi_o = 1'b1; sat_lo_o = 1'b0; end
            REG_LOWER:  begin sat_hi_o = 1'b0; sat_lo_o = 1'b1; end
            REG_LINEAR: begin sat_hi_o = 1'b0; sat_lo_o = 1'b0; end
            default:    begin sat_hi_o = 1'b0; sat_lo_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pi_aw_checker.sv
module pi_aw_checker #(
    parameter int DW        = 16,
    parameter int GW        = 12,
    parameter int ACC_GUARD = 6,
    parameter int OW        = 16,
    parameter int OUT_MAX   = 1000,
    localparam int AW = DW + GW + 2 + ACC_GUARD,
    localparam int SW = AW + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_stb,
    input logic signed [SW-1:0] req_o,
    input logic        [OW-1:0] cmd_o,
    input logic                 sat_hi_o,
    input logic                 sat_lo_o,
    input logic                 err_pos,
    input logic                 err_neg,
    input logic signed [AW-1:0] acc_q
);

    // R1: reset clears the outputs
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (req_o == '0 && cmd_o == '0 && !sat_hi_o && !sat_lo_o));

    // R3: command stays inside the actuator range
    assert_cmd_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_o <= OW'(OUT_MAX));

    // R3: flags agree with the limit values of the command
    assert_flag_matches_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (sat_hi_o |-> cmd_o == OW'(OUT_MAX)) and (sat_lo_o |-> cmd_o == '0));

    // R4: flags are exclusive
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(sat_hi_o && sat_lo_o));

    // R5: freeze at the upper limit with positive error
    assert_freeze_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && sat_hi_o && err_pos) |=> (acc_q == $past(acc_q)));

    // R6: freeze at the lower limit with negative error
    assert_freeze_lower_R6: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && sat_lo_o && err_neg) |=> (acc_q == $past(acc_q)));

    // R10: outputs hold between strobes
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(req_o) && $stable(cmd_o) && $stable(sat_hi_o) && $stable(sat_lo_o)));

endmodule

bind pi_antiwindup_ctrl pi_aw_checker #(
    .DW(DW), .GW(GW), .ACC_GUARD(ACC_GUARD), .OW(OW), .OUT_MAX(OUT_MAX)
) u_pi_aw_checker (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .req_o    (req_o),
    .cmd_o    (cmd_o),
    .sat_hi_o (sat_hi_o),
    .sat_lo_o (sat_lo_o),
    .err_pos  (err_pos_w),
    .err_neg  (err_neg_w),
    .acc_q    (acc_q_w)
);

// File: tb/test_pi_antiwindup_ctrl.sv
`timescale 1ns/1ps
module test_pi_antiwindup_ctrl;

    typedef struct {
        longint req;
        longint cmd;
        bit     hi;
        bit     lo;
        string  tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               stb_m = 1'b0;
    logic               stb_w = 1'b0;
    logic signed [15:0] sp = '0;
    logic signed [15:0] pv = '0;
    logic        [11:0] kp = '0;
    logic        [11:0] ki = '0;

    logic signed [36:0] req_m;
    logic        [15:0] cmd_m;
    logic               hi_m, lo_m;
    logic signed [30:0] req_w;
    logic        [15:0] cmd_wd;
    logic               hi_w, lo_w;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Model state per instance: 0 = main, 1 = wide
    longint m_acc [2];
    int     m_reg [2];   // 0 linear, 1 upper, 2 lower
    longint c_max [2] = '{1000, 65535};
    int     c_frac[2] = '{8, 16};
    int     c_aw  [2] = '{36, 30};

    exp_t q[$];
    exp_t last_m;

    always #5 clk = ~clk;

    pi_antiwindup_ctrl i_pi_antiwindup_ctrl (
        .clk(clk), .rst(rst), .smp_stb(stb_m),
        .setpoint_i(sp), .measured_i(pv), .kp_i(kp), .ki_i(ki),
        .req_o(req_m), .cmd_o(cmd_m), .sat_hi_o(hi_m), .sat_lo_o(lo_m)
    );

    pi_antiwindup_ctrl #(.ACC_GUARD(0), .FRAC(16), .OUT_MAX(65535)) i_pi_antiwindup_ctrl_wide (
        .clk(clk), .rst(rst), .smp_stb(stb_w),
        .setpoint_i(sp), .measured_i(pv), .kp_i(kp), .ki_i(ki),
        .req_o(req_w), .cmd_o(cmd_wd), .sat_hi_o(hi_w), .sat_lo_o(lo_w)
    );

    function automatic exp_t model_step(int k, longint s, longint p, longint g_p,
                                        longint g_i, string tag);
        exp_t   e;
        longint err, amax, amin, tot, r;
        bit     frz;
        err  = s - p;
        amax = (64'sd1 <<< (c_aw[k] - 1)) - 1;
        amin = -(64'sd1 <<< (c_aw[k] - 1));
        frz  = (m_reg[k] == 1 && err > 0) || (m_reg[k] == 2 && err < 0);
        if (!frz) begin
            m_acc[k] = m_acc[k] + g_i * err;
            if (m_acc[k] > amax) m_acc[k] = amax;
            if (m_acc[k] < amin) m_acc[k] = amin;
        end
        tot = g_p * err + m_acc[k];
        r   = tot >>> c_frac[k];
        e.req = r;
        if (r >= c_max[k]) begin e.cmd = c_max[k]; m_reg[k] = 1; end
        else if (r <= 0)   begin e.cmd = 0;        m_reg[k] = 2; end
        else               begin e.cmd = r;        m_reg[k] = 0; end
        e.hi  = (m_reg[k] == 1);
        e.lo  = (m_reg[k] == 2);
        e.tag = tag;
        return e;
    endfunction

    function automatic void model_reset();
        for (int k = 0; k < 2; k++) begin
            m_acc[k] = 0;
            m_reg[k] = 0;
        end
    endfunction

    task automatic compare(string tag, longint ar, longint ac, bit ah, bit al, exp_t e);
        n_tests++;
        if (ar != e.req || ac != e.cmd || ah != e.hi || al != e.lo) begin
            n_fail++;
            $display("FAIL %s: req=%0d cmd=%0d hi=%0d lo=%0d expected req=%0d cmd=%0d hi=%0d lo=%0d",
                     tag, ar, ac, ah, al, e.req, e.cmd, e.hi, e.lo);
        end
    endtask

    // Driver for the main instance: pushes the expected result
    task automatic drive(int s, int p, int g_p, int g_i, string tag);
        exp_t e;
        @(negedge clk);
        sp = 16'(s); pv = 16'(p); kp = 12'(g_p); ki = 12'(g_i);
        stb_m = 1'b1;
        e = model_step(0, s, p, g_p, g_i, tag);
        q.push_back(e);
        last_m = e;
        @(negedge clk);
        stb_m = 1'b0;
    endtask

    // Wide-range instance: direct check
    task automatic drive_wide(int s, int p, int g_p, int g_i, string tag);
        exp_t e;
        @(negedge clk);
        sp = 16'(s); pv = 16'(p); kp = 12'(g_p); ki = 12'(g_i);
        stb_w = 1'b1;
        e = model_step(1, s, p, g_p, g_i, tag);
        @(negedge clk);
        stb_w = 1'b0;
        compare(tag, longint'(req_w), longint'(cmd_wd), hi_w, lo_w, e);
    endtask

    // Monitor: pops one expected item per strobe of the main instance
    initial begin
        forever begin
            @(posedge clk);
            if (stb_m) begin
                @(negedge clk);
                if (q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL scoreboard: result without expected item");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    compare(e.tag, longint'(req_m), longint'(cmd_m), hi_m, lo_m, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic check_cleared(string tag);
        exp_t z;
        z.req = 0; z.cmd = 0; z.hi = 0; z.lo = 0; z.tag = tag;
        compare(tag, longint'(req_m), longint'(cmd_m), hi_m, lo_m, z);
        compare(tag, longint'(req_w), longint'(cmd_wd), hi_w, lo_w, z);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_cleared("R1 reset state");

        // Linear region
        drive(500, 200, 256, 0, "R2 proportional linear");
        drive(100, 0, 0, 16, "R2 integral first sample");
        drive(100, 0, 0, 16, "R2 integral accumulates");

        // Upper limit
        drive(1000, 0, 256, 64, "R8 entering upper limit still integrates");
        drive(1000, 0, 256, 64, "R5 frozen at upper limit");
        drive(1000, 0, 256, 64, "R5 frozen again");
        drive(1000, 1100, 256, 64, "R7 negative error at upper limit integrates");
        drive(1000, 1200, 256, 64, "R7 unwinding continues");

        // Lower limit
        drive(0, 800, 256, 64, "R3 request below zero clamps");
        drive(0, 800, 256, 64, "R6 frozen at lower limit");
        drive(0, 900, 256, 64, "R6 frozen again");
        drive(0, -50, 256, 64, "R7 positive error at lower limit integrates");

        // Mid-run reset, then exact boundary requests
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_cleared("R1 reset after saturation");
        drive(1000, 0, 256, 0, "R4 request equal to OUT_MAX is upper");
        drive(0, 0, 256, 0, "R4 request equal to zero is lower");
        drive(300, 0, 256, 0, "R3 linear pass-through");

        // Idle: outputs must not move
        repeat (6) @(negedge clk);
        compare("R10 outputs hold without strobe", longint'(req_m), longint'(cmd_m),
                hi_m, lo_m, last_m);

        // Accumulator saturation in the wide-range instance
        drive_wide(32767, -32768, 0, 4095, "R9 first large step");
        drive_wide(32767, -32768, 0, 4095, "R9 second large step");
        drive_wide(32767, -32768, 0, 4095, "R9 accumulator stops at bound");

        repeat (3) @(negedge clk);
        n_tests++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard R2: %0d items left, expected 0", q.size());
        end
        finish_run();
    end

endmodule